// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block sits behind the instruction fetch of a machine whose memory is addressed in 12-bit cells. It receives the two cells at the instruction pointer as one 24-bit window, with the first cell in the upper half. From the leading bits it works out how many cells the instruction uses and extracts every field the later stages need. An instruction whose first cell begins with `11` is a short register-to-register form. A first cell that begins with `1111` opens the shift and operate space. Any other first cell starts a two-cell memory-reference or jump instruction.

The decode logic is purely combinational. Its result is captured in one register stage. When `in_valid` is high, the decoded result appears one clock later with `out_valid` high. When `in_valid` is low, the output fields keep their last values. The fetch unit uses the reported length to advance the instruction pointer by one or two cells. Any field that does not belong to the decoded form reads as zero. An unassigned code raises the illegal flag, zeroes every other field and reports one cell.

Top module: `insn_fmt_decoder`

## Requirements
- R1: `out_len2` is 1 for memory-reference, conditional-jump, subroutine/indexed-jump and shift instructions, and 0 for register, operate, mode-set and illegal instructions.
- R2: A first cell not starting with `11` is a memory reference with this layout: bits 11:6 are the opcode, bit 5 is the index flag, bits 4:3 are a 2-bit field, and bits 2:0 of the first cell followed by all 12 bits of the second cell form the 15-bit displacement. With the index flag at 0, the field names the destination register.
- R3: With the index flag at 1 on an ordinary memory reference, `out_idx_en` is 1 and `out_idx_sel` carries the field, including value 0. `out_dst` is forced to 0.
- R4: A first cell `11 oooooo dd ss`, not starting with `1111`, is a one-cell register form with opcode `oooooo`, destination `dd` and source `ss`.
- R5: Opcode `001101` is a conditional jump. Bits 5:3 give the condition: 001 greater, 010 equal, 011 greater-or-equal, 100 less, 101 not-equal, 110 less-or-equal, 111 always. The condition is reported on `out_jcond`, with `out_jcond_en` set.
- R6: Opcode `011000` with index flag 0 sets `out_jsr`, with the link index register on `out_dst` and no indexing. With index flag 1 it sets `out_xjump`, with `out_idx_en` 1 and the index register on `out_idx_sel`.
- R7: A first cell `1111 000 sss rr`, with `sss` in {000 logical right, 001 arithmetic right, 010 logical left, 100 rotate right, 101 rotate left}, is a shift. It sets `out_shift_en`, `out_shift_op`=`sss` and `out_dst`=`rr`, and the second cell is the shift count.
- R8: A first cell `1111 0100 xx rr` is an operate instruction (xx: 00 clear, 01 increment, 10 invert, 11 negate) reporting `out_oper_op` and `out_dst`. A first cell `1111 011111 c i` is a mode set with `out_mode_chr`=c and `out_mode_int`=i.
- R9: The following codes set `out_illegal`, report one cell and zero all other fields: opcode 000000 in either form, a conditional jump with condition 000, opcodes `001101` or `011000` in register form, and unused `1111` sub-codes.
- R10: Reset clears `out_valid` and every field. `out_valid` follows `in_valid` by one cycle, and the fields hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window is valid this cycle |
| in_bits | input | 24 | First cell in 23:12, second cell in 11:0 |
| out_valid | output | 1 | Decoded result valid |
| out_len2 | output | 1 | Instruction uses two cells |
| out_illegal | output | 1 | Unassigned code |
| out_opcode | output | 6 | Primary opcode (memory or register form) |
| out_dst | output | 2 | Destination / link / shifted register |
| out_src | output | 2 | Source register (register form) |
| out_idx_en | output | 1 | Indexing in use |
| out_idx_sel | output | 2 | Index register select |
| out_disp | output | 15 | Address displacement |
| out_jcond_en | output | 1 | Conditional jump |
| out_jcond | output | 3 | Jump condition |
| out_jsr | output | 1 | Jump to subroutine |
| out_xjump | output | 1 | Indexed unconditional jump |
| out_shift_en | output | 1 | Shift instruction |
| out_shift_op | output | 3 | Shift kind |
| out_shift_cnt | output | 12 | Shift count |
| out_oper_en | output | 1 | Operate instruction |
| out_oper_op | output | 2 | Operate kind |
| out_mode_set | output | 1 | Mode-set instruction |
| out_mode_chr | output | 1 | 12-bit character select |
| out_mode_int | output | 1 | 36-bit integer select |

## Verification
The assertions assume `rst` and `in_valid` are driven cleanly on clock-cycle boundaries. They also assume that nothing else is known about `in_bits`, so every 24-bit pattern is legal input and must still produce a consistent, mutually exclusive class report. The stimulus changes inputs only on the falling edge. It covers each instruction class, boundary displacements of zero and all ones, index register 0, and every family of unassigned codes, so that each class-exclusion and field-zeroing property is exercised from both sides.

// File: rtl/insn_fmt_pkg.sv
package insn_fmt_pkg;
    localparam int CELL_W = 12;
    localparam int WIN_W  = 2 * CELL_W;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 2;
    localparam int DISP_W = 15;
    localparam int HI_DISP_W = DISP_W - CELL_W;

    localparam logic [OPC_W-1:0] OPC_NONE  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JCOND = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_JSUB  = 6'b011000;

    typedef struct packed {
        logic              len2;
        logic              illegal;
        logic [OPC_W-1:0]  opcode;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic              idx_en;
        logic [REG_W-1:0]  idx_sel;
        logic [DISP_W-1:0] disp;
        logic              jcond_en;
        logic [2:0]        jcond;
        logic              jsr;
        logic              xjump;
        logic              shift_en;
        logic [2:0]        shift_op;
        logic [CELL_W-1:0] shift_cnt;
        logic              oper_en;
        logic [1:0]        oper_op;
        logic              mode_set;
        logic              mode_chr;
        logic              mode_int;
    } dec_t;

    function automatic logic shift_kind_ok(input logic [2:0] k);
        return (k == 3'b000) || (k == 3'b001) || (k == 3'b010) ||
               (k == 3'b100) || (k == 3'b101);
    endfunction

    function automatic dec_t illegal_result();
        dec_t d;
        d = '0;
        d.illegal = 1'b1;
        return d;
    endfunction
endpackage

// File: rtl/insn_mem_dec.sv
module insn_mem_dec
    import insn_fmt_pkg::*;
(
    input  logic [CELL_W-1:0] cell0,
    input  logic [CELL_W-1:0] cell1,
    output dec_t              res
);
    logic [OPC_W-1:0] opc;
    logic             xflag;
    logic [REG_W-1:0] fld;

    assign opc   = cell0[CELL_W-1 -: OPC_W];
    assign xflag = cell0[5];
    assign fld   = cell0[4:3];

    always_comb begin
        res = '0;
        if (opc == OPC_NONE) begin
            res = illegal_result();
        end else begin
            res.len2   = 1'b1;
            res.opcode = opc;
            res.disp   = {cell0[HI_DISP_W-1:0], cell1};
            if (opc == OPC_JCOND) begin
                if (cell0[5:3] == 3'b000) begin
                    res = illegal_result();
                end else begin
                    res.jcond_en = 1'b1;
                    res.jcond    = cell0[5:3];
                end
            end else if (opc == OPC_JSUB) begin
                if (!xflag) begin
                    res.jsr = 1'b1;
                    res.dst = fld;
                end else begin
                    res.xjump   = 1'b1;
                    res.idx_en  = 1'b1;
                    res.idx_sel = fld;
                end
            end else if (xflag) begin
                res.idx_en  = 1'b1;
                res.idx_sel = fld;
            end else begin
                res.dst = fld;
            end
        end
    end
endmodule

// File: rtl/insn_short_dec.sv
module insn_short_dec
    import insn_fmt_pkg::*;
(
    input  logic [CELL_W-1:0] cell0,
    input  logic [CELL_W-1:0] cell1,
    output dec_t              res
);
    logic             ext_space;
    logic [OPC_W-1:0] ropc;

    assign ext_space = (cell0[11:8] == 4'hF);
    assign ropc      = cell0[9:4];

    always_comb begin
        res = '0;
        if (ext_space) begin
            if (cell0[7:5] == 3'b000 && shift_kind_ok(cell0[4:2])) begin
                res.len2      = 1'b1;
                res.shift_en  = 1'b1;
                res.shift_op  = cell0[4:2];
                res.dst       = cell0[1:0];
                res.shift_cnt = cell1;
            end else if (cell0[7:4] == 4'b0100) begin
                res.oper_en = 1'b1;
                res.oper_op = cell0[3:2];
                res.dst     = cell0[1:0];
            end else if (cell0[7:2] == 6'b011111) begin
                res.mode_set = 1'b1;
                res.mode_chr = cell0[1];
                res.mode_int = cell0[0];
            end else begin
                res = illegal_result();
            end
        end else if (ropc == OPC_NONE || ropc == OPC_JCOND || ropc == OPC_JSUB) begin
            res = illegal_result();
        end else begin
            res.opcode = ropc;
            res.dst    = cell0[3:2];
            res.src    = cell0[1:0];
        end
    end
endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
    import insn_fmt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [2*CELL_W-1:0]      in_bits,
    output logic                     out_valid,
    output logic                     out_len2,
    output logic                     out_illegal,
    output logic [OPC_W-1:0]         out_opcode,
    output logic [REG_W-1:0]         out_dst,
    output logic [REG_W-1:0]         out_src,
    output logic                     out_idx_en,
    output logic [REG_W-1:0]         out_idx_sel,
    output logic [DISP_W-1:0]        out_disp,
    output logic                     out_jcond_en,
    output logic [2:0]               out_jcond,
    output logic                     out_jsr,
    output logic                     out_xjump,
    output logic                     out_shift_en,
    output logic [2:0]               out_shift_op,
    output logic [CELL_W-1:0]        out_shift_cnt,
    output logic                     out_oper_en,
    output logic [1:0]               out_oper_op,
    output logic                     out_mode_set,
    output logic                     out_mode_chr,
    output logic                     out_mode_int
);
    logic [CELL_W-1:0] cell0, cell1;
    dec_t mem_res, short_res, nxt, held;
    logic valid_q;

    assign cell0 = in_bits[WIN_W-1 -: CELL_W];
    assign cell1 = in_bits[CELL_W-1:0];

    insn_mem_dec   u_mem   (.cell0(cell0), .cell1(cell1), .res(mem_res));
    insn_short_dec u_short (.cell0(cell0), .cell1(cell1), .res(short_res));

    assign nxt = (cell0[11:10] == 2'b11) ? short_res : mem_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            held    <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) held <= nxt;
        end
    end

    assign out_valid     = valid_q;
    assign out_len2      = held.len2;
    assign out_illegal   = held.illegal;
    assign out_opcode    = held.opcode;
    assign out_dst       = held.dst;
    assign out_src       = held.src;
    assign out_idx_en    = held.idx_en;
    assign out_idx_sel   = held.idx_sel;
    assign out_disp      = held.disp;
    assign out_jcond_en  = held.jcond_en;
    assign out_jcond     = held.jcond;
    assign out_jsr       = held.jsr;
    assign out_xjump     = held.xjump;
    assign out_shift_en  = held.shift_en;
    assign out_shift_op  = held.shift_op;
    assign out_shift_cnt = held.shift_cnt;
    assign out_oper_en   = held.oper_en;
    assign out_oper_op   = held.oper_op;
    assign out_mode_set  = held.mode_set;
    assign out_mode_chr  = held.mode_chr;
    assign out_mode_int  = held.mode_int;
endmodule

// File: rtl/insn_fmt_checker.sv
module insn_fmt_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [23:0] in_bits,
    input logic        out_valid,
    input logic        out_len2,
    input logic        out_illegal,
    input logic [5:0]  out_opcode,
    input logic [1:0]  out_dst,
    input logic [1:0]  out_src,
    input logic        out_idx_en,
    input logic [1:0]  out_idx_sel,
    input logic [14:0] out_disp,
    input logic        out_jcond_en,
    input logic [2:0]  out_jcond,
    input logic        out_jsr,
    input logic        out_xjump,
    input logic        out_shift_en,
    input logic [2:0]  out_shift_op,
    input logic [11:0] out_shift_cnt,
    input logic        out_oper_en,
    input logic        out_mode_set
);
    p_illegal_short_r1: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !out_len2);

    p_shift_long_r7: assert property (@(posedge clk) disable iff (rst)
        out_shift_en |-> out_len2);

    p_index_dst_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (out_idx_en && !out_xjump) |-> (out_dst == 2'd0));

    p_jsr_unindexed_r6: assert property (@(posedge clk) disable iff (rst)
        out_jsr |-> !out_idx_en);

    p_jcond_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        out_jcond_en |-> (out_jcond != 3'd0));

    p_class_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_illegal, out_jcond_en, out_jsr, out_xjump,
                  out_shift_en, out_oper_en, out_mode_set}));

    p_illegal_clean_r9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_opcode == 6'd0 && out_disp == 15'd0 && out_dst == 2'd0
                         && out_src == 2'd0 && out_shift_cnt == 12'd0));

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_opcode) && $stable(out_disp) && $stable(out_len2)
                       && $stable(out_shift_op) && $stable(out_dst)));

    wire unused_ok = ^{in_bits};
endmodule

bind insn_fmt_decoder insn_fmt_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .out_valid(out_valid), .out_len2(out_len2), .out_illegal(out_illegal),
    .out_opcode(out_opcode), .out_dst(out_dst), .out_src(out_src),
    .out_idx_en(out_idx_en), .out_idx_sel(out_idx_sel), .out_disp(out_disp),
    .out_jcond_en(out_jcond_en), .out_jcond(out_jcond), .out_jsr(out_jsr),
    .out_xjump(out_xjump), .out_shift_en(out_shift_en), .out_shift_op(out_shift_op),
    .out_shift_cnt(out_shift_cnt), .out_oper_en(out_oper_en), .out_mode_set(out_mode_set)
);

// File: tb/sim_insn_fmt_decoder.sv
module sim_insn_fmt_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [23:0] in_bits = '0;
    logic out_valid, out_len2, out_illegal, out_idx_en, out_jcond_en, out_jsr, out_xjump;
    logic out_shift_en, out_oper_en, out_mode_set, out_mode_chr, out_mode_int;
    logic [5:0]  out_opcode;
    logic [1:0]  out_dst, out_src, out_idx_sel, out_oper_op;
    logic [14:0] out_disp;
    logic [2:0]  out_jcond, out_shift_op;
    logic [11:0] out_shift_cnt;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    insn_fmt_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .out_valid(out_valid), .out_len2(out_len2), .out_illegal(out_illegal),
        .out_opcode(out_opcode), .out_dst(out_dst), .out_src(out_src),
        .out_idx_en(out_idx_en), .out_idx_sel(out_idx_sel), .out_disp(out_disp),
        .out_jcond_en(out_jcond_en), .out_jcond(out_jcond), .out_jsr(out_jsr),
        .out_xjump(out_xjump), .out_shift_en(out_shift_en), .out_shift_op(out_shift_op),
        .out_shift_cnt(out_shift_cnt), .out_oper_en(out_oper_en), .out_oper_op(out_oper_op),
        .out_mode_set(out_mode_set), .out_mode_chr(out_mode_chr), .out_mode_int(out_mode_int)
    );

    // expected bundle: len2, illegal, opcode, dst, src, idx_en, idx_sel, disp,
    // class flags {jcond, jsr, xjump, mode, shift, oper}, aux, shift count
    localparam int NV = 21;
    localparam logic [74:0] VEC [NV] = '{
        {24'h08DABC, 1'b1,1'b0,6'h02,2'd1,2'd0,1'b0,2'd0,15'h5ABC,6'b000000,3'b000,12'h000}, // R2 R1
        {24'h120007, 1'b1,1'b0,6'h04,2'd0,2'd0,1'b1,2'd0,15'h0007,6'b000000,3'b000,12'h000}, // R3 index 0
        {24'h0FFFFF, 1'b1,1'b0,6'h03,2'd0,2'd0,1'b1,2'd3,15'h7FFF,6'b000000,3'b000,12'h000}, // R3 max disp
        {24'h350100, 1'b1,1'b0,6'h0D,2'd0,2'd0,1'b0,2'd0,15'h0100,6'b100000,3'b010,12'h000}, // R5 equal
        {24'h37C001, 1'b1,1'b0,6'h0D,2'd0,2'd0,1'b0,2'd0,15'h4001,6'b100000,3'b111,12'h000}, // R5 always
        {24'h610200, 1'b1,1'b0,6'h18,2'd2,2'd0,1'b0,2'd0,15'h0200,6'b010000,3'b000,12'h000}, // R6 jsr
        {24'h628000, 1'b1,1'b0,6'h18,2'd0,2'd0,1'b1,2'd1,15'h0000,6'b001000,3'b000,12'h000}, // R6 xjump
        {24'hC5B123, 1'b0,1'b0,6'h05,2'd2,2'd3,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R4
        {24'hEF1FFF, 1'b0,1'b0,6'h2F,2'd0,2'd1,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R4 top opcode
        {24'hF0600A, 1'b1,1'b0,6'h00,2'd2,2'd0,1'b0,2'd0,15'h0000,6'b000010,3'b001,12'h00A}, // R7 asr
        {24'hF15FFF, 1'b1,1'b0,6'h00,2'd1,2'd0,1'b0,2'd0,15'h0000,6'b000010,3'b101,12'hFFF}, // R7 rol
        {24'hF4F777, 1'b0,1'b0,6'h00,2'd3,2'd0,1'b0,2'd0,15'h0000,6'b000001,3'b011,12'h000}, // R8 neg
        {24'hF40000, 1'b0,1'b0,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000001,3'b000,12'h000}, // R8 clear
        {24'hF7E000, 1'b0,1'b0,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000100,3'b010,12'h000}, // R8 mode
        {24'h000555, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 op 0
        {24'hF0C123, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 shift 011
        {24'hC05000, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 reg op 0
        {24'h340FFF, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 cond 000
        {24'hF80000, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 space
        {24'hCD0000, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}, // R9 reg jump
        {24'hF18000, 1'b0,1'b1,6'h00,2'd0,2'd0,1'b0,2'd0,15'h0000,6'b000000,3'b000,12'h000}  // R9 shift 110
    };
    string tags [NV] = '{"R2","R3","R3","R5","R5","R6","R6","R4","R4","R7","R7",
                         "R8","R8","R8","R9","R9","R9","R9","R9","R9","R9"};

    function automatic logic [50:0] got_bundle();
        logic [2:0] aux;
        aux = out_jcond | out_shift_op | {1'b0, out_oper_op} | {1'b0, out_mode_chr, out_mode_int};
        return {out_len2, out_illegal, out_opcode, out_dst, out_src, out_idx_en, out_idx_sel,
                out_disp, {out_jcond_en, out_jsr, out_xjump, out_mode_set, out_shift_en, out_oper_en},
                aux, out_shift_cnt};
    endfunction

    task automatic check(input string tag, input logic [50:0] got, input logic [50:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL R10: watchdog expired, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [50:0] last;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {50'd0, out_valid}, 51'd0);
        check("R10", got_bundle(), 51'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_bits  = VEC[i][74:51];
            @(negedge clk);
            check(tags[i], got_bundle(), VEC[i][50:0]);
            check("R10", {50'd0, out_valid}, 51'd1);
        end

        // R10: fields hold and valid drops while in_valid is low
        in_valid = 1'b1;
        in_bits  = VEC[0][74:51];
        @(negedge clk);
        last = got_bundle();
        in_valid = 1'b0;
        in_bits  = VEC[9][74:51];
        @(negedge clk);
        check("R10", {50'd0, out_valid}, 51'd0);
        check("R10", got_bundle(), last);
        @(negedge clk);
        check("R10", got_bundle(), last);

        // R1: length follows the new window when valid returns
        in_valid = 1'b1;
        @(negedge clk);
        check("R1", {50'd0, out_len2}, 51'd1);
        in_bits = VEC[7][74:51];
        @(negedge clk);
        check("R1", {50'd0, out_len2}, 51'd0);

        // R10: synchronous reset clears a loaded result
        rst = 1'b1;
        @(negedge clk);
        check("R10", got_bundle(), 51'd0);
        check("R10", {50'd0, out_valid}, 51'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule